// File: doc/BRIEF.md
# Asynchronous DRAM Access Sequencer

This block sits between a host that issues single-word read and write requests and an asynchronous DRAM whose row and column addresses share one set of pins. Each accepted request becomes one complete strobe sequence: the row is placed on the address bus and the row strobe falls, the column follows, and the column strobe falls. For a write, the write-enable strobe is low and data is driven before that edge. For a read, the output-enable strobe is low and data is sampled a set number of cycles later. The row strobe then returns high and stays high for the precharge time.

All analog delays are counted in controller clock cycles and set through parameters: the row-to-column delay, the minimum row-active time, the precharge time and the column-access delay. The host sees a valid/ready request channel and a read-data strobe. The DRAM side drives a separate output-enable for an external tristate buffer on the data bus.

Top module: `dram_seq_ctrl`

## Requirements
- R1: The row half of the request is on `dram_addr` for at least one cycle before `dram_ras_n` falls and is unchanged at that edge.
- R2: The column half is on `dram_addr` for at least one cycle before `dram_cas_n` falls, is unchanged at that edge, and `dram_ras_n` is low then.
- R3: At the `dram_cas_n` falling edge, `dram_we_n` is high for a read (`req_write`=0). For a write (`req_write`=1) it is low, with `dram_dq_oe`=1 and `dram_dq_out` holding the request data, both stable since the cycle before.
- R4: `dram_cas_n` falls no sooner than max(T_RCD, 2) cycles after `dram_ras_n` falls.
- R5: `dram_ras_n` stays low for at least T_RAS cycles, and `dram_cas_n` is high whenever `dram_ras_n` rises.
- R6: Between two accesses, `dram_ras_n` stays high for at least T_RP cycles.
- R7: `dram_oe_n` is low only while `dram_cas_n` is low during a read. `dram_dq_oe` is high only during writes. The two are never active together.
- R8: `req_ready` is high in idle, falls on the cycle after a request is accepted, and stays low until the precharge time has ended.
- R9: A read samples `dram_dq_in` exactly T_CAC cycles after `dram_cas_n` falls. The sampled value appears on `rd_data` with a single-cycle `rd_valid` pulse, 1+max(T_RCD,2)+T_CAC cycles after the accepting edge. A write raises no `rd_valid`.
- R10: During and after reset all four strobes are high, `dram_dq_oe` and `rd_valid` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | AW | Row half of the word address |
| req_col | input | AW | Column half of the word address |
| req_wdata | input | DW | Write data |
| rd_data | output | DW | Read data |
| rd_valid | output | 1 | One-cycle strobe marking rd_data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Memory output enable, active low |
| dram_addr | output | AW | Multiplexed row/column address |
| dram_dq_out | output | DW | Data toward the memory |
| dram_dq_oe | output | 1 | Enables the external driver of dram_dq_out |
| dram_dq_in | input | DW | Data from the memory |

## Verification
The bench pairs the sequencer with a behavioural memory that latches the row and column on the strobe edges. Until the column strobe has been low for T_CAC cycles, the model returns the inverted word, so sampling one cycle early gives wrong data. Writes followed by reads to the same location check the basic path. Two locations whose row and column values are swapped detect a mix-up of the two address halves. Row and column values of all ones against all zeros detect dropped or stuck address bits. Requests issued back to back as soon as ready rises test the precharge and row-active spacing at its tightest, and every write is checked for the absence of a read strobe.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_ACT   = 2'd2,
      ST_PRE   = 2'd3
   } dseq_state_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dseq_tick_counter.sv
module dseq_tick_counter #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          run,
   output logic [CW-1:0] cnt
);

   localparam logic [CW-1:0] ONE = CW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= ONE;
      else if (run && (cnt != '1))
         cnt <= cnt + ONE;
   end

endmodule

// File: rtl/dseq_strobe_fsm.sv
module dseq_strobe_fsm
   import dseq_pkg::*;
#(
   parameter int CW       = 4,
   parameter int RCD_EFF  = 2,
   parameter int CAS_HOLD = 2,
   parameter int RAS_END  = 5,
   parameter int T_RP     = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [CW-1:0] cnt,
   output logic          req_ready,
   output logic          cnt_load,
   output logic          cnt_run,
   output logic          load,
   output logic          sel_col,
   output logic          capture,
   output logic          ras_n,
   output logic          cas_n,
   output logic          we_n,
   output logic          oe_n,
   output logic          dq_oe
);

   localparam logic [CW-1:0] K_COL     = CW'(1);
   localparam logic [CW-1:0] K_CASFALL = CW'(RCD_EFF);
   localparam logic [CW-1:0] K_CASRISE = CW'(RCD_EFF + CAS_HOLD);
   localparam logic [CW-1:0] K_RASRISE = CW'(RAS_END);
   localparam logic [CW-1:0] K_PREDONE = CW'(T_RP);

   dseq_state_e state;
   logic        wr_q;
   logic        cas_fall, cas_rise, ras_rise, pre_done;

   always_comb begin
      sel_col  = (state == ST_ACT) && (cnt == K_COL);
      cas_fall = (state == ST_ACT) && (cnt == K_CASFALL);
      cas_rise = (state == ST_ACT) && (cnt == K_CASRISE);
      ras_rise = (state == ST_ACT) && (cnt == K_RASRISE);
      pre_done = (state == ST_PRE) && (cnt == K_PREDONE);
      req_ready = (state == ST_IDLE);
      load     = (state == ST_IDLE) && req_valid;
      capture  = cas_rise && !wr_q;
      cnt_load = (state == ST_SETUP) || ras_rise;
      cnt_run  = (state == ST_ACT) || (state == ST_PRE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         wr_q  <= 1'b0;
         ras_n <= 1'b1;
         cas_n <= 1'b1;
         we_n  <= 1'b1;
         oe_n  <= 1'b1;
         dq_oe <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  wr_q  <= req_write;
                  state <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               ras_n <= 1'b0;
               state <= ST_ACT;
            end
            ST_ACT: begin
               if (sel_col && wr_q) begin
                  we_n  <= 1'b0;
                  dq_oe <= 1'b1;
               end
               if (cas_fall) begin
                  cas_n <= 1'b0;
                  oe_n  <= wr_q;
               end
               if (cas_rise) begin
                  cas_n <= 1'b1;
                  we_n  <= 1'b1;
                  oe_n  <= 1'b1;
                  dq_oe <= 1'b0;
               end
               if (ras_rise) begin
                  ras_n <= 1'b1;
                  state <= ST_PRE;
               end
            end
            ST_PRE: begin
               if (pre_done)
                  state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dseq_addr_data.sv
module dseq_addr_data #(
   parameter int AW = 12,
   parameter int DW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          sel_col,
   input  logic          capture,
   input  logic [AW-1:0] req_row,
   input  logic [AW-1:0] req_col,
   input  logic [DW-1:0] req_wdata,
   input  logic [DW-1:0] dq_in,
   output logic [AW-1:0] addr,
   output logic [DW-1:0] dq_out,
   output logic [DW-1:0] rd_data,
   output logic          rd_valid
);

   logic [AW-1:0] col_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr     <= '0;
         col_q    <= '0;
         dq_out   <= '0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         if (load) begin
            addr   <= req_row;
            col_q  <= req_col;
            dq_out <= req_wdata;
         end else if (sel_col) begin
            addr <= col_q;
         end
         if (capture)
            rd_data <= dq_in;
         rd_valid <= capture;
      end
   end

endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
   import dseq_pkg::*;
#(
   parameter int AW    = 12,
   parameter int DW    = 4,
   parameter int T_RCD = 2,
   parameter int T_RAS = 5,
   parameter int T_RP  = 3,
   parameter int T_CAC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [AW-1:0] req_row,
   input  logic [AW-1:0] req_col,
   input  logic [DW-1:0] req_wdata,
   output logic [DW-1:0] rd_data,
   output logic          rd_valid,
   output logic          dram_ras_n,
   output logic          dram_cas_n,
   output logic          dram_we_n,
   output logic          dram_oe_n,
   output logic [AW-1:0] dram_addr,
   output logic [DW-1:0] dram_dq_out,
   output logic          dram_dq_oe,
   input  logic [DW-1:0] dram_dq_in
);

   // The column address needs one cycle on the bus after the row hold
   localparam int RCD_EFF = imax(T_RCD, 2);
   localparam int RAS_END = imax(RCD_EFF + T_CAC, T_RAS);
   localparam int CW      = $clog2(imax(RAS_END, T_RP) + 2);

   if (AW < 1) begin : g_bad_aw
      $error("dram_seq_ctrl: AW must be at least 1");
   end
   if (DW < 1) begin : g_bad_dw
      $error("dram_seq_ctrl: DW must be at least 1");
   end
   if (T_RCD < 1 || T_RAS < 1 || T_RP < 1 || T_CAC < 1) begin : g_bad_timing
      $error("dram_seq_ctrl: every timing parameter must be at least 1");
   end

   logic [CW-1:0] cnt;
   logic          cnt_load, cnt_run, load, sel_col, capture;

   dseq_tick_counter #(.CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (cnt_load),
      .run   (cnt_run),
      .cnt   (cnt)
   );

   dseq_strobe_fsm #(
      .CW       (CW),
      .RCD_EFF  (RCD_EFF),
      .CAS_HOLD (T_CAC),
      .RAS_END  (RAS_END),
      .T_RP     (T_RP)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .cnt       (cnt),
      .req_ready (req_ready),
      .cnt_load  (cnt_load),
      .cnt_run   (cnt_run),
      .load      (load),
      .sel_col   (sel_col),
      .capture   (capture),
      .ras_n     (dram_ras_n),
      .cas_n     (dram_cas_n),
      .we_n      (dram_we_n),
      .oe_n      (dram_oe_n),
      .dq_oe     (dram_dq_oe)
   );

   dseq_addr_data #(.AW(AW), .DW(DW)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .sel_col   (sel_col),
      .capture   (capture),
      .req_row   (req_row),
      .req_col   (req_col),
      .req_wdata (req_wdata),
      .dq_in     (dram_dq_in),
      .addr      (dram_addr),
      .dq_out    (dram_dq_out),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid)
   );

endmodule

// File: rtl/dseq_checker.sv
module dseq_checker #(
   parameter int AW    = 12,
   parameter int DW    = 4,
   parameter int T_RCD = 2,
   parameter int T_RAS = 5,
   parameter int T_RP  = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_ready,
   input logic          rd_valid,
   input logic          dram_ras_n,
   input logic          dram_cas_n,
   input logic          dram_we_n,
   input logic          dram_oe_n,
   input logic [AW-1:0] dram_addr,
   input logic [DW-1:0] dram_dq_out,
   input logic          dram_dq_oe
);

   logic [15:0] lo_cnt, hi_cnt;
   logic        prev_ras, seen_pre;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_cnt   <= '0;
         hi_cnt   <= '0;
         prev_ras <= 1'b1;
         seen_pre <= 1'b0;
      end else begin
         prev_ras <= dram_ras_n;
         if (dram_ras_n && !prev_ras)
            seen_pre <= 1'b1;
         if (dram_ras_n) begin
            lo_cnt <= '0;
            if (hi_cnt != '1) hi_cnt <= hi_cnt + 16'd1;
         end else begin
            hi_cnt <= '0;
            if (lo_cnt != '1) lo_cnt <= lo_cnt + 16'd1;
         end
      end
   end

   a_r1_row_setup: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |-> $stable(dram_addr));

   a_r2_col_setup: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_cas_n) |-> ($stable(dram_addr) && !dram_ras_n));

   a_r3_wr_data_setup: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dram_cas_n) && !dram_we_n) |->
         (dram_dq_oe && $stable(dram_dq_out) && $stable(dram_we_n)));

   a_r4_row_to_col: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_cas_n) |-> (lo_cnt >= 16'(T_RCD)));

   a_r5_active_time: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dram_ras_n) |-> ((lo_cnt >= 16'(T_RAS)) && dram_cas_n));

   a_r6_precharge: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dram_ras_n) && seen_pre) |-> (hi_cnt >= 16'(T_RP)));

   a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_oe_n |-> (!dram_dq_oe && dram_we_n && !dram_cas_n));

   a_r8_busy_while_open: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_ras_n |-> !req_ready);

   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

endmodule

bind dram_seq_ctrl dseq_checker #(
   .AW(AW), .DW(DW), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP)
) u_dseq_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_ready   (req_ready),
   .rd_valid    (rd_valid),
   .dram_ras_n  (dram_ras_n),
   .dram_cas_n  (dram_cas_n),
   .dram_we_n   (dram_we_n),
   .dram_oe_n   (dram_oe_n),
   .dram_addr   (dram_addr),
   .dram_dq_out (dram_dq_out),
   .dram_dq_oe  (dram_dq_oe)
);

// File: tb/tb_dram_seq_ctrl.sv
`timescale 1ns/100ps
module tb_dram_seq_ctrl;

   localparam int AW = 12, DW = 4;
   localparam int T_RCD = 2, T_RAS = 5, T_RP = 3, T_CAC = 2;
   localparam int RCD_EFF = (T_RCD > 2) ? T_RCD : 2;
   localparam int RD_LAT  = 1 + RCD_EFF + T_CAC;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_row = '0, req_col = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rd_valid;
   logic [DW-1:0] rd_data;
   logic ras_n, cas_n, we_n, oe_n, dq_oe;
   logic [AW-1:0] addr;
   logic [DW-1:0] dq_out;
   logic [DW-1:0] dq_in = '0;

   int tests = 0, fails = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   dram_seq_ctrl #(.AW(AW), .DW(DW), .T_RCD(T_RCD), .T_RAS(T_RAS),
                   .T_RP(T_RP), .T_CAC(T_CAC)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_row(req_row), .req_col(req_col),
      .req_wdata(req_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
      .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
      .dram_oe_n(oe_n), .dram_addr(addr), .dram_dq_out(dq_out),
      .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // ---------------- memory model ----------------
   logic [DW-1:0] mem [logic [2*AW-1:0]];
   logic [AW-1:0] row_l = '0, p_addr = '0;
   logic [DW-1:0] p_dq = '0;
   logic p_ras = 1, p_cas = 1, p_dq_oe = 0, seen_rise = 0;
   int lo = 0, hi = 0, cas_lo = 0;

   function automatic logic [DW-1:0] rd_mem(input logic [2*AW-1:0] k);
      if (mem.exists(k)) return mem[k];
      return '0;
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         if (p_ras && !ras_n) begin
            chk(addr == p_addr, "R1 row addr stable at RAS fall", addr, p_addr);
            if (seen_rise) chk(hi >= T_RP, "R6 precharge time", hi, T_RP);
            row_l = addr;
         end
         if (p_cas && !cas_n) begin
            chk(!ras_n && addr == p_addr, "R2 col addr stable at CAS fall", addr, p_addr);
            chk(lo >= RCD_EFF, "R4 row-to-column delay", lo, RCD_EFF);
            if (!we_n) begin
               chk(dq_oe && p_dq_oe && dq_out == p_dq, "R3 write data set up", dq_out, p_dq);
               mem[{row_l, addr}] = dq_out;
            end else begin
               chk(!dq_oe, "R3 read keeps bus released", dq_oe, 0);
            end
         end
         if (!p_ras && ras_n) begin
            chk(lo >= T_RAS, "R5 row active time", lo, T_RAS);
            chk(cas_n, "R5 CAS high at RAS rise", cas_n, 1);
            seen_rise = 1;
         end
         chk(!(dq_oe && !oe_n), "R7 no bus contention", {dq_oe, oe_n}, 2'b01);
         if (!oe_n) chk(we_n && !cas_n, "R7 OE only on read column", {we_n, cas_n}, 2'b10);
         if (ras_n) begin hi++; lo = 0; end
         else begin lo = (p_ras ? 1 : lo + 1); hi = 0; end
         cas_lo = cas_n ? 0 : cas_lo + 1;
         if (!ras_n && !cas_n && we_n && !oe_n)
            dq_in = (cas_lo >= T_CAC) ? rd_mem({row_l, addr}) : ~rd_mem({row_l, addr});
         else
            dq_in = '0;
         p_ras = ras_n; p_cas = cas_n; p_addr = addr; p_dq = dq_out; p_dq_oe = dq_oe;
      end
   end

   // ---------------- host access ----------------
   task automatic access(input bit wr, input logic [AW-1:0] r, input logic [AW-1:0] c,
                         input logic [DW-1:0] wd, output logic [DW-1:0] rd,
                         output int lat, output int pulses);
      int guard = 0;
      rd = '0; lat = -1; pulses = 0;
      @(negedge clk);
      while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
      req_valid = 1; req_write = wr; req_row = r; req_col = c; req_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      chk(!req_ready, "R8 ready low after accept", req_ready, 0);
      for (int n = 0; n < 60; n++) begin
         if (rd_valid) begin
            if (pulses == 0) begin lat = n; rd = rd_data; end
            pulses++;
         end
         if (req_ready) break;
         @(negedge clk);
      end
      chk(req_ready, "R8 ready returns after precharge", req_ready, 1);
   endtask

   task automatic do_write(input logic [AW-1:0] r, input logic [AW-1:0] c, input logic [DW-1:0] d);
      logic [DW-1:0] rd; int lat, pulses;
      access(1'b1, r, c, d, rd, lat, pulses);
      chk(pulses == 0, "R9 write gives no rd_valid", pulses, 0);
   endtask

   task automatic do_read(input logic [AW-1:0] r, input logic [AW-1:0] c, input logic [DW-1:0] exp);
      logic [DW-1:0] rd; int lat, pulses;
      access(1'b0, r, c, '0, rd, lat, pulses);
      chk(pulses == 1, "R9 single rd_valid pulse", pulses, 1);
      chk(lat == RD_LAT, "R9 read latency", lat, RD_LAT);
      chk(rd == exp, "R9 read data", rd, exp);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      @(negedge clk);
      chk(ras_n && cas_n && we_n && oe_n, "R10 strobes high in reset",
          {ras_n, cas_n, we_n, oe_n}, 4'hF);
      chk(!dq_oe && !rd_valid, "R10 bus and rd_valid idle", {dq_oe, rd_valid}, 0);
      chk(req_ready, "R10 ready in reset", req_ready, 1);
   endtask

   task automatic t_basic();
      do_write(12'h005, 12'h009, 4'hA);
      do_read(12'h005, 12'h009, 4'hA);
   endtask

   task automatic t_swap();
      do_write(12'h009, 12'h005, 4'h3);
      do_write(12'h005, 12'h009, 4'hC);
      do_read(12'h009, 12'h005, 4'h3);
      do_read(12'h005, 12'h009, 4'hC);
   endtask

   task automatic t_extremes();
      do_write(12'hFFF, 12'h000, 4'h6);
      do_write(12'h000, 12'hFFF, 4'h9);
      do_write(12'hFFF, 12'hFFF, 4'hF);
      do_read(12'h000, 12'hFFF, 4'h9);
      do_read(12'hFFF, 12'h000, 4'h6);
      do_read(12'hFFF, 12'hFFF, 4'hF);
   endtask

   task automatic t_back_to_back();
      for (int i = 0; i < 6; i++) do_write(12'(16 * i + 1), 12'(i * 7), 4'(i + 2));
      for (int i = 5; i >= 0; i--) do_read(12'(16 * i + 1), 12'(i * 7), 4'(i + 2));
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1;
      repeat (2) @(negedge clk);
      t_reset();
      t_basic();
      t_swap();
      t_extremes();
      t_back_to_back();
      repeat (5) @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule